// File: doc/BRIEF.md
# Serial Memory Read Engine

This block is the device side of a serial-peripheral-interface memory, limited to its read path. A host pulls chip select low, clocks in an eight-bit command on the data input, and either receives the contents of a byte-wide internal array or the device status byte on the data output. An array read takes a sixteen-bit address after the command. From the falling clock edge after the last address bit, the engine streams bytes for as long as the host keeps clocking. The byte pointer advances after each byte and wraps from the top of the array back to zero.

The engine samples the serial pins with the chip's own fast clock. It detects serial clock edges internally, so every register sits in one clock domain. A `busy` input stands for an internal write cycle. While it is high, a status read returns all ones, so only the ready flag carries meaning. The array is filled through a plain write port before any traffic starts. The serial output is released (high impedance) whenever the engine is not shifting read or status data.

Top module: `sermem_read_core`

## Requirements
- R1: After reset, and while chip select (`cs_n`) is high, `so_en` is 0 and `so` is not driven.
- R2: Command 8'h03, sent MSB first, starts an array read. It is followed by a 16-bit address, MSB first, of which only the low ADDR_W bits (10 by default) select the byte.
- R3: The first data bit (the MSB of the addressed byte) appears on `so` after the serial clock falling edge that follows the rising edge carrying the last address bit. Each later bit follows the next falling edge, MSB first.
- R4: As long as clocking continues, consecutive bytes from consecutive addresses are delivered without limit.
- R5: After the byte at the highest address (ADDR_W bits all ones), the next byte comes from address 0.
- R6: Raising `cs_n` ends any command, including one in the middle of a byte. Output is released, and the next select starts again at command decoding.
- R7: Command 8'h05 returns the status byte, MSB first, starting at the falling edge after the last command bit, and repeats it while clocking continues. With `busy` low the byte is STATUS_IDLE (8'h00, ready flag bit 0 = 0).
- R8: A status read is accepted while `busy` is high and then returns 8'hFF.
- R9: `so_en` stays 0 while the command and address bits are being received.
- R10: Any command other than 8'h03 or 8'h05 leaves `so_en` at 0 for the rest of that select, even if later bits look like a valid command.
- R11: Both serial modes with input sampled on the rising edge work: clock idle low (mode 0) and clock idle high (mode 3).
- R12: A write on the preload port (`pl_we` high for one clock) stores `pl_data` at `pl_addr`, and later array reads return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data into the engine |
| busy | input | 1 | High while an internal write cycle is modelled |
| pl_we | input | 1 | Preload write strobe |
| pl_addr | input | ADDR_W | Preload byte address |
| pl_data | input | 8 | Preload byte value |
| so | output | 1 | Serial data out, high impedance when released |
| so_en | output | 1 | High while `so` is driven |

## Verification
The checker watches four things on every clock. The output is released while select is deasserted or has only just fallen. It stays quiet during command and address reception and after an unrecognised command. A driven data bit changes only after a detected serial clock falling edge. Which byte arrives, the low-bit address masking, the wrap from the top address, the status values with and without `busy`, the behaviour in both clock modes and the restart after an aborted read can only be shown by the bench's transactions against its scoreboard.

// File: rtl/sermem_pkg.sv
package sermem_pkg;
    localparam int CMD_W  = 8;
    localparam int ADDR_FIELD_W = 16;
    localparam int BYTE_W = 8;

    localparam logic [CMD_W-1:0] CMD_ARRAY_RD  = 8'h03;
    localparam logic [CMD_W-1:0] CMD_STATUS_RD = 8'h05;

    typedef enum logic [2:0] {
        PH_CMD    = 3'd0,
        PH_ADDR   = 3'd1,
        PH_ARRAY  = 3'd2,
        PH_STATUS = 3'd3,
        PH_IGNORE = 3'd4
    } phase_e;
endpackage

// File: rtl/sermem_pin_sampler.sv
// Registers the serial pins into the block clock domain and finds SCK edges.
module sermem_pin_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic sel,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_s
);
    typedef struct packed {
        logic sck1;
        logic sck2;
        logic si1;
        logic sel1;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d      = smp_q;
        smp_d.sck1 = sck;
        smp_d.sck2 = smp_q.sck1;
        smp_d.si1  = si;
        smp_d.sel1 = ~cs_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    assign sel      = smp_q.sel1;
    assign sck_rise = smp_q.sck1 & ~smp_q.sck2;
    assign sck_fall = ~smp_q.sck1 & smp_q.sck2;
    assign si_s     = smp_q.si1;
endmodule

// File: rtl/sermem_array.sv
// Byte array with a preload write port and a combinational read port.
module sermem_array #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              pl_we,
    input  logic [ADDR_W-1:0] pl_addr,
    input  logic [7:0]        pl_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (pl_we) mem_q[pl_addr] <= pl_data;
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/sermem_ctrl.sv
// Command decode, address collection and output shifting.
module sermem_ctrl
    import sermem_pkg::*;
#(
    parameter int          ADDR_W      = 10,
    parameter logic [7:0]  STATUS_IDLE = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              si_s,
    input  logic              busy,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              so_bit,
    output logic              so_drv,
    output phase_e            phase
);
    localparam int CNT_W   = $clog2(ADDR_FIELD_W) + 1;
    localparam int IDX_W   = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_FIELD_W - 1);
    localparam logic [IDX_W-1:0] IDX_MSB   = IDX_W'(BYTE_W - 1);

    typedef struct packed {
        phase_e                  phase;
        logic [CNT_W-1:0]        cnt;
        logic [ADDR_FIELD_W-1:0] shift;
        logic [ADDR_W-1:0]       ptr;
        logic [IDX_W-1:0]        idx;
        logic [7:0]              stat;
        logic                    so;
        logic                    so_en;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        phase: PH_CMD, cnt: '0, shift: '0, ptr: '0,
        idx: '0, stat: '0, so: 1'b0, so_en: 1'b0
    };

    ctl_t ctl_d, ctl_q;

    logic [ADDR_FIELD_W-1:0] shift_in;
    logic [CMD_W-1:0]        cmd_in;
    logic [7:0]              stat_now;

    assign shift_in = {ctl_q.shift[ADDR_FIELD_W-2:0], si_s};
    assign cmd_in   = shift_in[CMD_W-1:0];
    assign stat_now = busy ? 8'hFF : STATUS_IDLE;

    always_comb begin
        ctl_d = ctl_q;
        if (!sel) begin
            ctl_d = CTL_RST;
        end else begin
            if (sck_rise) begin
                unique case (ctl_q.phase)
                    PH_CMD: begin
                        ctl_d.shift = shift_in;
                        ctl_d.cnt   = ctl_q.cnt + 1'b1;
                        if (ctl_q.cnt == CMD_LAST) begin
                            ctl_d.cnt = '0;
                            ctl_d.idx = IDX_MSB;
                            if (cmd_in == CMD_ARRAY_RD) begin
                                ctl_d.phase = PH_ADDR;
                            end else if (cmd_in == CMD_STATUS_RD) begin
                                ctl_d.phase = PH_STATUS;
                                ctl_d.stat  = stat_now;
                            end else begin
                                ctl_d.phase = PH_IGNORE;
                            end
                        end
                    end
                    PH_ADDR: begin
                        ctl_d.shift = shift_in;
                        ctl_d.cnt   = ctl_q.cnt + 1'b1;
                        if (ctl_q.cnt == ADDR_LAST) begin
                            ctl_d.ptr   = shift_in[ADDR_W-1:0];
                            ctl_d.idx   = IDX_MSB;
                            ctl_d.phase = PH_ARRAY;
                        end
                    end
                    default: ;
                endcase
            end
            if (sck_fall) begin
                unique case (ctl_q.phase)
                    PH_ARRAY: begin
                        ctl_d.so    = rd_data[ctl_q.idx];
                        ctl_d.so_en = 1'b1;
                        if (ctl_q.idx == '0) begin
                            ctl_d.idx = IDX_MSB;
                            ctl_d.ptr = ctl_q.ptr + 1'b1;
                        end else begin
                            ctl_d.idx = ctl_q.idx - 1'b1;
                        end
                    end
                    PH_STATUS: begin
                        ctl_d.so    = ctl_q.stat[ctl_q.idx];
                        ctl_d.so_en = 1'b1;
                        if (ctl_q.idx == '0) begin
                            ctl_d.idx  = IDX_MSB;
                            ctl_d.stat = stat_now;
                        end else begin
                            ctl_d.idx = ctl_q.idx - 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign rd_addr = ctl_q.ptr;
    assign so_bit  = ctl_q.so;
    assign so_drv  = ctl_q.so_en;
    assign phase   = ctl_q.phase;
endmodule

// File: rtl/sermem_read_core.sv
module sermem_read_core
    import sermem_pkg::*;
#(
    parameter int         ADDR_W      = 10,
    parameter logic [7:0] STATUS_IDLE = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    input  logic              busy,
    input  logic              pl_we,
    input  logic [ADDR_W-1:0] pl_addr,
    input  logic [7:0]        pl_data,
    output logic              so,
    output logic              so_en
);
    logic              sel;
    logic              sck_rise;
    logic              sck_fall;
    logic              si_s;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data;
    logic              so_bit;
    phase_e            cur_phase;

    sermem_pin_sampler u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .si       (si),
        .sel      (sel),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .si_s     (si_s)
    );

    sermem_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .pl_we   (pl_we),
        .pl_addr (pl_addr),
        .pl_data (pl_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    sermem_ctrl #(.ADDR_W(ADDR_W), .STATUS_IDLE(STATUS_IDLE)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .si_s     (si_s),
        .busy     (busy),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .so_bit   (so_bit),
        .so_drv   (so_en),
        .phase    (cur_phase)
    );

    assign so = so_en ? so_bit : 1'bz;
endmodule

// File: rtl/sermem_read_chk.sv
module sermem_read_chk
    import sermem_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   cs_n,
    input logic   so_en,
    input logic   so_bit,
    input logic   sck_fall,
    input phase_e cur_phase
);
    // R1: released once deselect has been seen for three samples
    p_release_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !so_en);

    // R6: output may only be driven if select was low two samples earlier
    p_drive_needs_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
        so_en |-> !$past(cs_n, 2));

    // R3: a driven bit only changes after a detected falling edge
    p_change_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (so_en && $past(so_en) && !$past(sck_fall)) |-> $stable(so_bit));

    // R9: quiet while command and address bits arrive
    p_quiet_on_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_phase == PH_CMD || cur_phase == PH_ADDR) |-> !so_en);

    // R10: quiet for the rest of a select after an unknown command
    p_quiet_on_unknown_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_phase == PH_IGNORE) |-> !so_en);
endmodule

bind sermem_read_core sermem_read_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .so_en     (so_en),
    .so_bit    (so_bit),
    .sck_fall  (sck_fall),
    .cur_phase (cur_phase)
);

// File: tb/sermem_read_core_tb.sv
module sermem_read_core_tb;
    localparam int AW   = 10;
    localparam int HALF = 6;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          sck = 1'b0;
    logic          si = 1'b0;
    logic          busy = 1'b0;
    logic          pl_we = 1'b0;
    logic [AW-1:0] pl_addr = '0;
    logic [7:0]    pl_data = '0;
    wire           so;
    logic          so_en;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    exp_t       exp_q[$];
    logic [7:0] got_q[$];

    always #2 clk = ~clk;

    sermem_read_core u_dut (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sck (sck), .si (si),
        .busy (busy), .pl_we (pl_we), .pl_addr (pl_addr), .pl_data (pl_data),
        .so (so), .so_en (so_en)
    );

    function automatic logic [7:0] pattern(int a);
        return 8'((a * 37 + 11) ^ (a >> 3));
    endfunction

    logic [7:0] model [1 << AW];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic b, output logic so_s, output logic oe_s);
        sck = 1'b0;
        si  = b;
        wait_clk(HALF);
        so_s = so;
        oe_s = so_en;
        sck  = 1'b1;
        wait_clk(HALF);
    endtask

    task automatic begin_xfer(input bit mode3);
        sck = mode3;
        wait_clk(HALF);
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic end_xfer(input bit mode3);
        sck = mode3;
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(2 * HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, inout bit any_oe);
        logic s, o;
        for (int i = 7; i >= 0; i--) begin
            sbit(b[i], s, o);
            any_oe |= o;
        end
    endtask

    task automatic recv_byte(output logic [7:0] v, output bit all_oe);
        logic s, o;
        all_oe = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            sbit(1'b0, s, o);
            v[i] = s;
            all_oe &= o;
        end
    endtask

    task automatic expect_byte(input logic [7:0] v, input string tag);
        exp_t e;
        e.val = v;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic collect(input int n, input string tag);
        logic [7:0] v;
        bit oe;
        for (int k = 0; k < n; k++) begin
            recv_byte(v, oe);
            chk(oe, {tag, " so_en during data"}, 0, 1);
            got_q.push_back(v);
        end
    endtask

    task automatic array_read(input bit mode3, input logic [15:0] addr,
                              input int n, input string tag);
        bit any_oe = 1'b0;
        for (int k = 0; k < n; k++)
            expect_byte(model[(int'(addr[AW-1:0]) + k) % (1 << AW)], tag);
        begin_xfer(mode3);
        send_byte(8'h03, any_oe);
        send_byte(addr[15:8], any_oe);
        send_byte(addr[7:0], any_oe);
        chk(!any_oe, "R9 quiet during command/address", int'(any_oe), 0);
        collect(n, tag);
        end_xfer(mode3);
    endtask

    // Monitor: pops expected items as observed bytes arrive
    initial begin
        exp_t e;
        logic [7:0] g;
        forever begin
            @(negedge clk);
            while (got_q.size() > 0) begin
                g = got_q.pop_front();
                if (exp_q.size() == 0) begin
                    chk(1'b0, "scoreboard unexpected byte", int'(g), 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(g == e.val, e.tag, int'(g), int'(e.val));
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit any_oe;
        logic [7:0] v;
        bit oe;
        logic s, o;

        wait_clk(5);
        chk(so_en == 1'b0, "R1 so_en in reset", int'(so_en), 0);
        rst_n = 1'b1;
        wait_clk(3);
        chk(so_en == 1'b0, "R1 so_en idle after reset", int'(so_en), 0);

        // R12: preload the array through the write port
        for (int a = 0; a < (1 << AW); a++) begin
            model[a] = pattern(a);
            pl_we = 1'b1; pl_addr = AW'(a); pl_data = pattern(a);
            wait_clk(1);
        end
        pl_we = 1'b0;
        wait_clk(2);

        // R2 R3 R4: mode 0, upper address bits ignored
        array_read(1'b0, 16'hFC05, 4, "R2 R3 R4 masked address stream");
        chk(so_en == 1'b0, "R1 released after deselect", int'(so_en), 0);

        // R5 R11: mode 3, wrap past the top address
        array_read(1'b1, 16'h03FE, 4, "R5 R11 wrap in mode 3");

        // R7: status idle, repeated byte
        expect_byte(8'h00, "R7 status idle");
        expect_byte(8'h00, "R7 status repeats");
        any_oe = 1'b0;
        begin_xfer(1'b0);
        send_byte(8'h05, any_oe);
        chk(!any_oe, "R9 quiet during status command", int'(any_oe), 0);
        collect(2, "R7");
        end_xfer(1'b0);

        // R8: status while busy, mode 3
        busy = 1'b1;
        expect_byte(8'hFF, "R8 status busy");
        expect_byte(8'hFF, "R8 status busy repeat");
        any_oe = 1'b0;
        begin_xfer(1'b1);
        send_byte(8'h05, any_oe);
        collect(2, "R8");
        end_xfer(1'b1);
        busy = 1'b0;

        // R10: unknown command, then bits that resemble a read
        any_oe = 1'b0;
        begin_xfer(1'b0);
        send_byte(8'h07, any_oe);
        send_byte(8'h03, any_oe);
        send_byte(8'h00, any_oe);
        send_byte(8'h10, any_oe);
        for (int i = 0; i < 16; i++) begin
            sbit(1'b0, s, o);
            any_oe |= o;
        end
        end_xfer(1'b0);
        chk(!any_oe, "R10 no output after unknown command", int'(any_oe), 0);

        // R6: abort in the middle of a byte, then restart
        any_oe = 1'b0;
        begin_xfer(1'b0);
        send_byte(8'h03, any_oe);
        send_byte(8'h01, any_oe);
        send_byte(8'h00, any_oe);
        for (int i = 0; i < 3; i++) sbit(1'b0, s, o);
        chk(so_en == 1'b1, "R6 driving before abort", int'(so_en), 1);
        end_xfer(1'b0);
        chk(so_en == 1'b0, "R6 released after abort", int'(so_en), 0);
        array_read(1'b0, 16'h0200, 2, "R6 fresh read after abort");

        // R12: overwrite one location and read it back
        model[9'h1A0] = 8'h5C;
        pl_we = 1'b1; pl_addr = AW'(10'h1A0); pl_data = 8'h5C;
        wait_clk(1);
        pl_we = 1'b0;
        wait_clk(2);
        array_read(1'b1, 16'h01A0, 1, "R12 preload overwrite");

        wait_clk(10);
        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        chk(got_q.size() == 0, "scoreboard no leftovers", got_q.size(), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule